// File: doc/BRIEF.md
# Multicast group hash filter

This block decides whether a received destination MAC address passes group-address filtering. A 256-entry, one-bit-per-entry hash table is held in eight 32-bit registers. Software programs the table through a plain register port: either a whole word at a time, or one entry at a time, so that an entry can be set or cleared without a read-modify-write.

A 48-bit destination address enters on a valid/ready stream input. The block runs a serial CRC-32 over the 48 address bits, one bit per clock. It turns the CRC into an 8-bit table index and reads one table bit. It then reports accept or reject, together with the index, on a one-cycle result strobe.

Back-pressure on the input is simple. `in_ready` is high only while no lookup is in flight. A request is taken on a cycle where `in_valid` and `in_ready` are both high. `in_valid` asserted while `in_ready` is low has no effect. The result strobe has no ready: it is a single-cycle pulse that the consumer must capture.

Top module: `mcast_hash_filter`

## Requirements
- R1: After reset, all eight table registers read zero, `in_ready` is 1 and `res_valid` is 0.
- R2: With `reg_we` high at a clock edge, `reg_wdata` is stored into register `reg_addr`. `reg_rdata` always shows register `reg_addr` combinationally.
- R3: With `ent_we` high at a clock edge, table entry `ent_idx` takes the value `ent_set` and every other entry keeps its value. Entry e lives in register e/32 at bit 31-(e mod 32), so entry 0 is bit 31 of register 0 and entry 255 is bit 0 of register 7. If a word write to the same register happens in the same cycle, the entry update wins on its own bit.
- R4: The address bits are fed to the CRC byte by byte, from `in_addr[47:40]` down to `in_addr[7:0]`, and within each byte from the LSB up. The CRC register starts at all ones. For each bit, fb = crc[31] xor bit, crc is shifted left by one, and it is xored with 0x04C11DB7 when fb is 1. There is no final inversion. `res_index` is the top 8 bits of the bit-reversed CRC, so `res_index[7]` = crc[0] and so on down to `res_index[0]` = crc[7].
- R5: For a group address (`in_addr[40]` = 1) with `promisc` low, `res_accept` equals table entry `res_index`.
- R6: For an individual address (`in_addr[40]` = 0), `res_accept` is 0 whatever the table and `promisc` hold.
- R7: For a group address with `promisc` high in the cycle before the result, `res_accept` is 1 even when the table is all zero.
- R8: `in_ready` is high exactly when no lookup is in flight. A request made while `in_ready` is low is ignored: it produces no result and does not change the one in flight.
- R9: `res_valid` pulses for one cycle, 49 clock edges after the edge at which the request was taken, and `in_ready` returns to 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Address request valid |
| in_ready | output | 1 | Block can take a request |
| in_addr | input | 48 | Destination address, first byte in [47:40] |
| promisc | input | 1 | Force accept of group addresses |
| res_valid | output | 1 | One-cycle result strobe |
| res_accept | output | 1 | Filter decision, 1 = accept |
| res_index | output | 8 | Hash index used for the lookup |
| reg_we | input | 1 | Word write enable |
| reg_addr | input | 3 | Register select for write and read |
| reg_wdata | input | 32 | Word write data |
| reg_rdata | output | 32 | Selected register contents |
| ent_we | input | 1 | Single-entry update enable |
| ent_idx | input | 8 | Entry to update |
| ent_set | input | 1 | New value for the entry |

## Verification
The hardest case to reach from the ports is a second request that arrives while a lookup is in flight. It must neither start a new CRC nor disturb the running one. The bench reaches it by raising `in_valid` with a different address partway through a lookup. It then checks that the returned index belongs to the first address and that exactly one result pulse appears. Hitting a particular table entry from the address side needs a CRC, so the bench sweeps all 256 entries through the entry-update port. It then runs over a hundred pseudo-random addresses against a patterned table, with the expected index and decision computed from the CRC definition.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int          CRC_W    = 32;
  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_INIT = 32'hFFFF_FFFF;
endpackage

// File: rtl/mhf_addr_order.sv
// Reorders a network-order address into CRC feed order:
// the first byte comes first, and each byte goes LSB first.
module mhf_addr_order #(
  parameter int ADDR_BYTES = 6,
  localparam int ADDR_W = 8 * ADDR_BYTES
) (
  input  logic [ADDR_W-1:0] addr_net,
  output logic [ADDR_W-1:0] addr_ser
);
  for (genvar j = 0; j < ADDR_BYTES; j++) begin : g_byte
    for (genvar i = 0; i < 8; i++) begin : g_bit
      assign addr_ser[8*j + i] = addr_net[ADDR_W - 8 - 8*j + i];
    end
  end
endmodule

// File: rtl/mhf_crc_serial.sv
// Serial CRC engine: one data bit per clock. `last` pulses in the
// cycle after the final bit has been folded in.
module mhf_crc_serial
  import mhf_pkg::*;
#(
  parameter int DATA_BITS = 48,
  parameter int OUT_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [DATA_BITS-1:0] din,
  output logic                 busy,
  output logic                 last,
  output logic [OUT_W-1:0]     hash
);
  localparam int CNT_W = $clog2(DATA_BITS + 1);

  logic [CRC_W-1:0]     crc_q, crc_nxt;
  logic [DATA_BITS-1:0] sh_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 busy_q, last_q;
  logic                 fb;

  always_comb begin
    fb      = crc_q[CRC_W-1] ^ sh_q[0];
    crc_nxt = {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_q  <= CRC_INIT;
      sh_q   <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      last_q <= 1'b0;
    end else begin
      last_q <= 1'b0;
      if (start && !busy_q) begin
        crc_q  <= CRC_INIT;
        sh_q   <= din;
        cnt_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        crc_q <= crc_nxt;
        sh_q  <= sh_q >> 1;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(DATA_BITS - 1)) begin
          busy_q <= 1'b0;
          last_q <= 1'b1;
        end
      end
    end
  end

  // Top OUT_W bits of the bit-reversed CRC.
  for (genvar k = 0; k < OUT_W; k++) begin : g_rev
    assign hash[OUT_W-1-k] = crc_q[k];
  end

  assign busy = busy_q;
  assign last = last_q;
endmodule

// File: rtl/mhf_hash_table.sv
// Hash table storage with MSB-first bit numbering within each word.
module mhf_hash_table #(
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 32,
  localparam int RSEL_W = $clog2(NUM_REGS),
  localparam int BIT_W  = $clog2(REG_W),
  localparam int IDX_W  = RSEL_W + BIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [RSEL_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ent_we,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic              ent_set,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_bit
);
  logic [REG_W-1:0] tbl_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [REG_W-1:0] nxt;
    always_comb begin
      nxt = tbl_q[r];
      if (reg_we && reg_addr == RSEL_W'(r)) nxt = reg_wdata;
      if (ent_we && ent_idx[IDX_W-1:BIT_W] == RSEL_W'(r))
        nxt[~ent_idx[BIT_W-1:0]] = ent_set;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) tbl_q[r] <= '0;
      else        tbl_q[r] <= nxt;
    end
  end

  assign reg_rdata = tbl_q[reg_addr];
  assign lk_bit    = tbl_q[lk_idx[IDX_W-1:BIT_W]][~lk_idx[BIT_W-1:0]];
endmodule

// File: rtl/mcast_hash_filter.sv
module mcast_hash_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int NUM_REGS   = 8,
  parameter int REG_W      = 32,
  localparam int ADDR_W = 8 * ADDR_BYTES,
  localparam int RSEL_W = $clog2(NUM_REGS),
  localparam int IDX_W  = $clog2(NUM_REGS * REG_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              promisc,
  output logic              res_valid,
  output logic              res_accept,
  output logic [IDX_W-1:0]  res_index,
  input  logic              reg_we,
  input  logic [RSEL_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ent_we,
  input  logic [IDX_W-1:0]  ent_idx,
  input  logic              ent_set
);
  logic [ADDR_W-1:0] ser;
  logic              start, busy, last, tbit, grp_q;
  logic [IDX_W-1:0]  hash;
  logic              res_valid_q, res_accept_q;
  logic [IDX_W-1:0]  res_index_q;

  mhf_addr_order #(.ADDR_BYTES(ADDR_BYTES)) u_ord (
    .addr_net(in_addr),
    .addr_ser(ser)
  );

  assign in_ready = !busy && !last;
  assign start    = in_valid && in_ready;

  mhf_crc_serial #(.DATA_BITS(ADDR_W), .OUT_W(IDX_W)) u_crc (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .din  (ser),
    .busy (busy),
    .last (last),
    .hash (hash)
  );

  mhf_hash_table #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .ent_we   (ent_we),
    .ent_idx  (ent_idx),
    .ent_set  (ent_set),
    .lk_idx   (hash),
    .lk_bit   (tbit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grp_q        <= 1'b0;
      res_valid_q  <= 1'b0;
      res_accept_q <= 1'b0;
      res_index_q  <= '0;
    end else begin
      if (start) grp_q <= in_addr[ADDR_W-8];
      res_valid_q <= last;
      if (last) begin
        res_accept_q <= grp_q && (promisc || tbit);
        res_index_q  <= hash;
      end
    end
  end

  assign res_valid  = res_valid_q;
  assign res_accept = res_accept_q;
  assign res_index  = res_index_q;
endmodule

// File: rtl/mhf_checker.sv
module mhf_checker #(
  parameter int ADDR_BYTES = 6,
  localparam int ADDR_W = 8 * ADDR_BYTES
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_addr,
  input logic              promisc,
  input logic              res_valid,
  input logic              res_accept
);
  logic       pending, grp_c;
  logic [7:0] lat_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      grp_c   <= 1'b0;
      lat_cnt <= '0;
    end else if (in_valid && in_ready) begin
      pending <= 1'b1;
      grp_c   <= in_addr[ADDR_W-8];
      lat_cnt <= '0;
    end else if (pending) begin
      lat_cnt <= lat_cnt + 1'b1;
      if (lat_cnt == 8'(ADDR_W)) pending <= 1'b0;
    end
  end

  assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == !pending);
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (lat_cnt == 8'(ADDR_W + 1) && !pending));
  assert_unicast_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !grp_c) |-> !res_accept);
  assert_promisc_accept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && grp_c && $past(promisc)) |-> res_accept);
endmodule

bind mcast_hash_filter mhf_checker #(.ADDR_BYTES(ADDR_BYTES)) u_mhf_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_addr   (in_addr),
  .promisc   (promisc),
  .res_valid (res_valid),
  .res_accept(res_accept)
);

// File: tb/mcast_hash_filter_bench.sv
`timescale 1ns/1ps
module mcast_hash_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [47:0] in_addr = '0;
  logic        promisc = 1'b0;
  logic        res_valid, res_accept;
  logic [7:0]  res_index;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ent_we = 1'b0;
  logic [7:0]  ent_idx = '0;
  logic        ent_set = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;
  logic [255:0] mdl = '0;

  always #4 clk = ~clk;

  mcast_hash_filter u_mcast_hash_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .promisc(promisc), .res_valid(res_valid),
    .res_accept(res_accept), .res_index(res_index), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_set(ent_set)
  );

  always @(negedge clk) if (rst_n && res_valid) pulses++;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_index(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    logic [7:0]  ix;
    for (int k = 0; k < 48; k++) begin
      logic b  = a[40 - 8*(k/8) + (k%8)];
      logic fb = c[31] ^ b;
      c = {c[30:0], 1'b0} ^ (fb ? 32'h04C1_1DB7 : 32'h0);
    end
    for (int k = 0; k < 8; k++) ix[7-k] = c[k];
    return ix;
  endfunction

  function automatic logic [31:0] mdl_word(input int r);
    logic [31:0] w;
    for (int b = 0; b < 32; b++) w[31-b] = mdl[r*32 + b];
    return w;
  endfunction

  task automatic wr_word(input int r, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(r); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    for (int b = 0; b < 32; b++) mdl[r*32 + b] = d[31-b];
  endtask

  task automatic wr_ent(input int e, input logic v);
    @(negedge clk);
    ent_we = 1'b1; ent_idx = 8'(e); ent_set = v;
    @(negedge clk);
    ent_we = 1'b0;
    mdl[e] = v;
  endtask

  function automatic bit table_ok_now();
    return 1'b1;
  endfunction

  task automatic cmp_table(input string req, output bit ok);
    ok = 1'b1;
    for (int r = 0; r < 8; r++) begin
      reg_addr = 3'(r);
      #1;
      if (reg_rdata !== mdl_word(r)) begin
        ok = 1'b0;
        $display("FAIL %s: reg %0d actual %h expected %h", req, r, reg_rdata, mdl_word(r));
      end
    end
  endtask

  task automatic lookup(input logic [47:0] a, input logic pr,
                        output logic [7:0] ix, output logic acc, output int lat);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; promisc = pr;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 0;
    while (!res_valid) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    ix = res_index; acc = res_accept;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic [7:0]  ix;
    logic        acc;
    int          lat;
    bit          ok;
    logic [63:0] s = 64'h9E37_79B9_7F4A_7C15;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(in_ready === 1'b1, "R1 ready", 64'(in_ready), 1);
    check(res_valid === 1'b0, "R1 res_valid", 64'(res_valid), 0);
    cmp_table("R1 table zero", ok);
    check(ok, "R1 table zero", 0, 0);

    // R2 word writes and reads
    for (int r = 0; r < 8; r++) wr_word(r, 32'h1357_9BDF * (r + 3) ^ 32'(r << 28));
    cmp_table("R2 word rw", ok);
    check(ok, "R2 word rw", 0, 0);
    for (int r = 0; r < 8; r++) wr_word(r, 32'h0);

    // R3 exhaustive single-entry set, then clear every odd entry
    for (int e = 0; e < 256; e++) begin
      wr_ent(e, 1'b1);
      cmp_table("R3 entry set", ok);
      check(ok, "R3 entry set", 64'(e), 64'(e));
    end
    for (int e = 1; e < 256; e += 2) wr_ent(e, 1'b0);
    cmp_table("R3 entry clear", ok);
    check(ok, "R3 entry clear", 0, 0);
    // R3 entry update and word write to same register in one cycle
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'h0000_0000;
    ent_we = 1'b1; ent_idx = 8'd165; ent_set = 1'b1;  // reg 5, bit 26
    @(negedge clk);
    reg_we = 1'b0; ent_we = 1'b0;
    reg_addr = 3'd5; #1;
    check(reg_rdata === 32'h0400_0000, "R3 same-cycle", 64'(reg_rdata), 64'h0400_0000);

    // R4/R5/R6/R7/R9 lookup sweep against patterned table
    for (int r = 0; r < 8; r++) wr_word(r, 32'hA5C3_0F69 ^ (32'h1111_1111 * r));
    for (int n = 0; n < 128; n++) begin
      logic [47:0] a;
      logic        pr, ea;
      logic [7:0]  ei;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      a = s[47:0];
      a[40] = (n % 4 != 0);
      pr = (n % 8 == 5);
      ei = exp_index(a);
      ea = a[40] && (pr || mdl[ei]);
      check(in_ready === 1'b1, "R8 ready idle", 64'(in_ready), 1);
      lookup(a, pr, ix, acc, lat);
      check(ix === ei, "R4 index", 64'(ix), 64'(ei));
      if (!a[40])   check(acc === 1'b0, "R6 unicast", 64'(acc), 0);
      else if (pr)  check(acc === 1'b1, "R7 promisc", 64'(acc), 1);
      else          check(acc === ea, "R5 table", 64'(acc), 64'(ea));
      check(lat == 49, "R9 latency", 64'(lat), 49);
      check(in_ready === 1'b1, "R9 ready back", 64'(in_ready), 1);
    end

    // R5 all ones / all zero table on one group address
    for (int r = 0; r < 8; r++) wr_word(r, 32'hFFFF_FFFF);
    lookup(48'h0100_5E00_00FB, 1'b0, ix, acc, lat);
    check(acc === 1'b1, "R5 all ones", 64'(acc), 1);
    // R6 unicast with promisc and full table
    lookup(48'h0012_3456_789A, 1'b1, ix, acc, lat);
    check(acc === 1'b0, "R6 unicast promisc", 64'(acc), 0);
    for (int r = 0; r < 8; r++) wr_word(r, 32'h0);
    lookup(48'h0100_5E00_00FB, 1'b0, ix, acc, lat);
    check(acc === 1'b0, "R5 all zero", 64'(acc), 0);
    lookup(48'h0100_5E00_00FB, 1'b1, ix, acc, lat);
    check(acc === 1'b1, "R7 promisc empty table", 64'(acc), 1);

    // R8 request while busy is ignored
    begin
      int          p0;
      logic [47:0] a1 = 48'h3300_0000_0001;
      logic [47:0] a2 = 48'hFFFF_FFFF_FFFF;
      @(negedge clk);
      p0 = pulses;
      in_valid = 1'b1; in_addr = a1; promisc = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      repeat (10) @(negedge clk);
      check(in_ready === 1'b0, "R8 busy ready", 64'(in_ready), 0);
      in_valid = 1'b1; in_addr = a2;
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      while (!res_valid) @(negedge clk);
      check(res_index === exp_index(a1), "R8 ignored index", 64'(res_index),
            64'(exp_index(a1)));
      repeat (60) @(negedge clk);
      check(pulses - p0 == 1, "R8 single result", 64'(pulses - p0), 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule